// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block serves several processor ports that share one small memory. Each port can issue a plain load, a plain store, a load-exclusive or a store-exclusive, with a byte address, up to 64 bits of write data, an access size and a shared-attribute bit. One request is granted per cycle by round-robin arbitration. The response comes back on a single bus one cycle later. It carries the port number, the load data and a status bit for store-exclusive.

The monitor keeps two kinds of reservation for each port. A non-shared load-exclusive only sets a per-port "reservation outstanding" flag, and a later non-shared store-exclusive checks that flag with no address compare. A shared load-exclusive records the 8-byte granule it touched, replacing any granule the port held before. A shared store-exclusive then succeeds only when its granule matches that record. Any write that completes to a shared address cancels matching shared reservations held by the other ports. Software retry loops built on load-exclusive and store-exclusive therefore see contention as a store-exclusive failure.

Top module: `excl_monitor`

## Requirements
- R1: Reset clears every non-shared flag, every shared reservation and the whole memory, and holds rsp_valid low.
- R2: At most one req_ready bit is high per cycle, only for a port with req_valid high. The search starts at the port after the last granted one, and the first grant after reset goes to port 0.
- R3: A grant in one cycle gives rsp_valid high in the next cycle, with rsp_port equal to the granted port. With no grant, rsp_valid is low.
- R4: Op encoding is 0 load, 1 store, 2 load-exclusive, 3 store-exclusive. Size encoding is 0 byte, 1 halfword, 2 word, 3 doubleword, and low address bits below the size are ignored. Loads return the addressed little-endian bytes right-justified and zero-extended. Stores and store-exclusives return rdata 0. Only store-exclusive can return status 1.
- R5: A shared load-exclusive replaces the port's earlier shared granule, so a later shared store-exclusive to the old granule fails.
- R6: A non-shared load-exclusive sets the port's outstanding flag.
- R7: A non-shared store-exclusive succeeds (status 0, memory written, flag cleared) only when the flag is set. Otherwise it returns status 1.
- R8: A shared store-exclusive succeeds (status 0, write, own reservation cleared) only when the port holds a shared reservation on that granule. Otherwise it returns status 1.
- R9: A failing store-exclusive leaves memory unchanged.
- R10: A completed store, or a successful store-exclusive, with the shared bit set clears the shared reservations that other ports hold on the same granule. It leaves their other granules and their non-shared flags alone. When two ports race, the first one granted wins.
- R11: Reservations match on the 8-byte granule (address bits above bit 2), whatever the access size and offset.
- R12: A doubleword access moves all 64 bits, with the low 32-bit register in rdata/wdata[31:0] at the lower address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | Request present, one bit per port |
| req_op | input | NP x 2 | Operation per port (R4 encoding) |
| req_size | input | NP x 2 | Access size per port (R4 encoding) |
| req_shared | input | NP | Shared attribute per port |
| req_addr | input | NP x AW | Byte address per port |
| req_wdata | input | NP x 64 | Write data per port, right-justified |
| req_ready | output | NP | Grant, one-hot or zero |
| rsp_valid | output | 1 | Response present |
| rsp_port | output | PW | Port the response belongs to |
| rsp_rdata | output | 64 | Load data |
| rsp_status | output | 1 | 1 when a store-exclusive failed |

## Verification
The hardest case to reach is a race in which two ports hold a reservation on the same granule and both present store-exclusive in the same cycle. Here arbitration order alone decides which store-exclusive wins. The bench first makes both ports take reservations one after the other, so the arbiter pointer sits at a known port. It then raises both store-exclusive requests together and checks that the earlier-granted port succeeds, that the other fails, and that memory holds only the winner's data. Clearing by a third party on a shared write is reached the same way, with a plain store placed between load-exclusive and store-exclusive.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    localparam int DATA_W     = 64;
    localparam int LANES      = DATA_W / 8;
    localparam int GRAN_SHIFT = 3;

    typedef enum logic [1:0] {
        OP_LD  = 2'd0,
        OP_ST  = 2'd1,
        OP_LDX = 2'd2,
        OP_STX = 2'd3
    } op_e;

    // byte offset of an access, aligned down to its own size
    function automatic logic [2:0] lane_off(input logic [1:0] sz, input logic [2:0] lo);
        logic [2:0] low_mask;
        low_mask = 3'((4'd1 << sz) - 4'd1);
        return lo & ~low_mask;
    endfunction

    function automatic logic [LANES-1:0] lane_be(input logic [1:0] sz, input logic [2:0] lo);
        logic [LANES-1:0] m;
        m = '0;
        for (int b = 0; b < LANES; b++) begin
            if (b < (1 << sz)) m[b] = 1'b1;
        end
        return m << lane_off(sz, lo);
    endfunction

    function automatic logic [DATA_W-1:0] size_keep(input logic [1:0] sz);
        logic [DATA_W-1:0] k;
        k = '0;
        for (int b = 0; b < LANES; b++) begin
            if (b < (1 << sz)) k[b*8 +: 8] = 8'hFF;
        end
        return k;
    endfunction

endpackage

// File: rtl/excl_rr_arb.sv
module excl_rr_arb #(
    parameter int NP = 4,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    output logic [NP-1:0] gnt,
    output logic [PW-1:0] gnt_idx,
    output logic          gnt_any
);

    localparam logic [PW-1:0] LAST_RST = PW'(NP - 1);

    logic [PW-1:0] last_d, last_q;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = 0; i < NP; i++) begin
            int cand;
            cand = (int'(last_q) + 1 + i) % NP;
            if (!gnt_any && req[cand]) begin
                gnt_any   = 1'b1;
                gnt_idx   = PW'(cand);
                gnt[cand] = 1'b1;
            end
        end
        last_d = gnt_any ? gnt_idx : last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= LAST_RST;
        else        last_q <= last_d;
    end

endmodule

// File: rtl/excl_resv_tbl.sv
module excl_resv_tbl
    import excl_mon_pkg::*;
#(
    parameter int NP = 4,
    parameter int GW = 4,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic [PW-1:0] acc_port,
    input  logic [1:0]    acc_op,
    input  logic          acc_shared,
    input  logic [GW-1:0] acc_gran,
    output logic          stx_pass,
    output logic          wr_commit
);

    typedef struct packed {
        logic [NP-1:0]         flag;
        logic [NP-1:0]         shv;
        logic [NP-1:0][GW-1:0] gran;
    } resv_t;

    resv_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        stx_pass  = 1'b0;
        wr_commit = 1'b0;
        if (acc_en) begin
            case (op_e'(acc_op))
                OP_LDX: begin
                    if (acc_shared) begin
                        s_d.shv[acc_port]  = 1'b1;
                        s_d.gran[acc_port] = acc_gran;
                    end else begin
                        s_d.flag[acc_port] = 1'b1;
                    end
                end
                OP_STX: begin
                    if (acc_shared) begin
                        stx_pass = s_q.shv[acc_port] && (s_q.gran[acc_port] == acc_gran);
                        if (stx_pass) s_d.shv[acc_port] = 1'b0;
                    end else begin
                        stx_pass = s_q.flag[acc_port];
                        if (stx_pass) s_d.flag[acc_port] = 1'b0;
                    end
                    wr_commit = stx_pass;
                end
                OP_ST:   wr_commit = 1'b1;
                default: ;
            endcase
            // a shared write cancels matching reservations of the other ports
            if (wr_commit && acc_shared) begin
                for (int q = 0; q < NP; q++) begin
                    if (PW'(q) != acc_port && s_q.shv[q] && s_q.gran[q] == acc_gran)
                        s_d.shv[q] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/excl_mem_bank.sv
module excl_mem_bank
    import excl_mon_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int GW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LANES-1:0]  be,
    input  logic [GW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [WORDS];

    assign rdata = mem_q[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
        end else if (we) begin
            for (int b = 0; b < LANES; b++) begin
                if (be[b]) mem_q[addr][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int NP        = 4,
    parameter int MEM_WORDS = 16,
    localparam int GW = $clog2(MEM_WORDS),
    localparam int AW = GW + GRAN_SHIFT,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NP-1:0]               req_valid,
    input  logic [NP-1:0][1:0]          req_op,
    input  logic [NP-1:0][1:0]          req_size,
    input  logic [NP-1:0]               req_shared,
    input  logic [NP-1:0][AW-1:0]       req_addr,
    input  logic [NP-1:0][DATA_W-1:0]   req_wdata,
    output logic [NP-1:0]               req_ready,
    output logic                        rsp_valid,
    output logic [PW-1:0]               rsp_port,
    output logic [DATA_W-1:0]           rsp_rdata,
    output logic                        rsp_status
);

    typedef struct packed {
        logic              valid;
        logic [PW-1:0]     port;
        logic [DATA_W-1:0] rdata;
        logic              status;
    } rsp_t;

    rsp_t r_d, r_q;

    logic [PW-1:0]     gnt_idx;
    logic              gnt_any;
    logic [1:0]        sel_op, sel_size;
    logic              sel_shared;
    logic [AW-1:0]     sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic [2:0]        offs;
    logic [LANES-1:0]  be;
    logic [GW-1:0]     gran;
    logic [DATA_W-1:0] wr_word, rd_word;
    logic              stx_pass, mem_we;

    excl_rr_arb #(.NP(NP)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (req_ready),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    always_comb begin
        sel_op     = req_op[gnt_idx];
        sel_size   = req_size[gnt_idx];
        sel_shared = req_shared[gnt_idx];
        sel_addr   = req_addr[gnt_idx];
        sel_wdata  = req_wdata[gnt_idx];
        offs       = lane_off(sel_size, sel_addr[2:0]);
        be         = lane_be(sel_size, sel_addr[2:0]);
        gran       = sel_addr[AW-1:GRAN_SHIFT];
        wr_word    = sel_wdata << {offs, 3'b000};
    end

    excl_resv_tbl #(.NP(NP), .GW(GW)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (gnt_any),
        .acc_port   (gnt_idx),
        .acc_op     (sel_op),
        .acc_shared (sel_shared),
        .acc_gran   (gran),
        .stx_pass   (stx_pass),
        .wr_commit  (mem_we)
    );

    excl_mem_bank #(.WORDS(MEM_WORDS)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .be    (be),
        .addr  (gran),
        .wdata (wr_word),
        .rdata (rd_word)
    );

    always_comb begin
        r_d        = r_q;
        r_d.valid  = gnt_any;
        r_d.port   = gnt_idx;
        r_d.status = gnt_any && (op_e'(sel_op) == OP_STX) && !stx_pass;
        if (gnt_any && (op_e'(sel_op) == OP_LD || op_e'(sel_op) == OP_LDX))
            r_d.rdata = (rd_word >> {offs, 3'b000}) & size_keep(sel_size);
        else
            r_d.rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid  = r_q.valid;
    assign rsp_port   = r_q.port;
    assign rsp_rdata  = r_q.rdata;
    assign rsp_status = r_q.status;

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk
    import excl_mon_pkg::*;
#(
    parameter int NP = 4,
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] req_valid,
    input logic [NP-1:0] req_ready,
    input logic          rsp_valid,
    input logic          rsp_status,
    input logic [PW-1:0] rsp_port,
    input logic [PW-1:0] gnt_idx,
    input logic [1:0]    gnt_op,
    input logic          mem_we
);

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    // R2
    grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    // R3
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> (rsp_valid && rsp_port == $past(gnt_idx)));

    // R3
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_ready) |=> !rsp_valid);

    // R9
    fail_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) && !mem_we && gnt_op == 2'(OP_STX) |=> rsp_status);

    // R4
    plain_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) && gnt_op != 2'(OP_STX) |=> !rsp_status);

endmodule

bind excl_monitor excl_monitor_chk #(.NP(NP), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_port   (rsp_port),
    .gnt_idx    (gnt_idx),
    .gnt_op     (sel_op),
    .mem_we     (mem_we)
);

// File: tb/tb_excl_monitor.sv
module tb_excl_monitor;

    localparam int NP = 4;
    localparam int AW = 7;
    localparam int PW = 2;
    localparam int NV = 33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]          req_valid = '0;
    logic [NP-1:0][1:0]     req_op = '0;
    logic [NP-1:0][1:0]     req_size = '0;
    logic [NP-1:0]          req_shared = '0;
    logic [NP-1:0][AW-1:0]  req_addr = '0;
    logic [NP-1:0][63:0]    req_wdata = '0;
    logic [NP-1:0]          req_ready;
    logic                   rsp_valid;
    logic [PW-1:0]          rsp_port;
    logic [63:0]            rsp_rdata;
    logic                   rsp_status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    excl_monitor dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_size(req_size), .req_shared(req_shared), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_port(rsp_port), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status)
    );

    typedef struct packed {
        logic [1:0]  port;
        logic [1:0]  op;
        logic [1:0]  size;
        logic        sh;
        logic [6:0]  addr;
        logic [63:0] wdata;
        logic        est;
        logic [63:0] erd;
    } vec_t;

    // op: 0 LD 1 ST 2 LDX 3 STX ; size: 0 B 1 H 2 W 3 D
    localparam vec_t VT [NV] = '{
        '{2'd0, 2'd1, 2'd2, 1'b0, 7'h08, 64'h11223344, 1'b0, 64'h0},          // R4
        '{2'd0, 2'd0, 2'd2, 1'b0, 7'h08, 64'h0, 1'b0, 64'h11223344},          // R4
        '{2'd0, 2'd0, 2'd0, 1'b0, 7'h09, 64'h0, 1'b0, 64'h33},                // R4
        '{2'd0, 2'd0, 2'd1, 1'b0, 7'h0A, 64'h0, 1'b0, 64'h1122},              // R4
        '{2'd1, 2'd3, 2'd2, 1'b0, 7'h10, 64'hAAAA, 1'b1, 64'h0},              // R7
        '{2'd1, 2'd0, 2'd2, 1'b0, 7'h10, 64'h0, 1'b0, 64'h0},                 // R9
        '{2'd1, 2'd2, 2'd2, 1'b0, 7'h10, 64'h0, 1'b0, 64'h0},                 // R6
        '{2'd1, 2'd3, 2'd2, 1'b0, 7'h10, 64'hBEEF, 1'b0, 64'h0},              // R7
        '{2'd1, 2'd0, 2'd2, 1'b0, 7'h10, 64'h0, 1'b0, 64'hBEEF},              // R7
        '{2'd1, 2'd3, 2'd2, 1'b0, 7'h10, 64'h1234, 1'b1, 64'h0},              // R7
        '{2'd1, 2'd0, 2'd2, 1'b0, 7'h10, 64'h0, 1'b0, 64'hBEEF},              // R9
        '{2'd2, 2'd2, 2'd3, 1'b1, 7'h20, 64'h0, 1'b0, 64'h0},                 // R8
        '{2'd2, 2'd3, 2'd2, 1'b1, 7'h24, 64'hCAFE, 1'b0, 64'h0},              // R11
        '{2'd2, 2'd0, 2'd3, 1'b0, 7'h20, 64'h0, 1'b0, 64'h0000CAFE00000000},  // R11
        '{2'd2, 2'd3, 2'd2, 1'b1, 7'h20, 64'h77, 1'b1, 64'h0},                // R8
        '{2'd2, 2'd2, 2'd2, 1'b1, 7'h20, 64'h0, 1'b0, 64'h0},                 // R5
        '{2'd2, 2'd2, 2'd2, 1'b1, 7'h28, 64'h0, 1'b0, 64'h0},                 // R5
        '{2'd2, 2'd3, 2'd2, 1'b1, 7'h20, 64'h99, 1'b1, 64'h0},                // R5
        '{2'd2, 2'd3, 2'd3, 1'b1, 7'h28, 64'h0123456789ABCDEF, 1'b0, 64'h0},  // R12
        '{2'd3, 2'd0, 2'd3, 1'b0, 7'h28, 64'h0, 1'b0, 64'h0123456789ABCDEF},  // R12
        '{2'd3, 2'd0, 2'd2, 1'b0, 7'h2C, 64'h0, 1'b0, 64'h01234567},          // R12
        '{2'd0, 2'd2, 2'd0, 1'b1, 7'h30, 64'h0, 1'b0, 64'h0},                 // R10
        '{2'd1, 2'd2, 2'd1, 1'b1, 7'h32, 64'h0, 1'b0, 64'h0},                 // R10
        '{2'd3, 2'd2, 2'd2, 1'b1, 7'h38, 64'h0, 1'b0, 64'h0},                 // R10
        '{2'd1, 2'd1, 2'd0, 1'b1, 7'h31, 64'h5A, 1'b0, 64'h0},                // R10
        '{2'd0, 2'd3, 2'd0, 1'b1, 7'h30, 64'h11, 1'b1, 64'h0},                // R10
        '{2'd3, 2'd3, 2'd2, 1'b1, 7'h38, 64'h7, 1'b0, 64'h0},                 // R10
        '{2'd0, 2'd2, 2'd2, 1'b0, 7'h40, 64'h0, 1'b0, 64'h0},                 // R10
        '{2'd1, 2'd1, 2'd2, 1'b1, 7'h40, 64'h55, 1'b0, 64'h0},                // R10
        '{2'd0, 2'd3, 2'd2, 1'b0, 7'h40, 64'h66, 1'b0, 64'h0},                // R10
        '{2'd0, 2'd0, 2'd2, 1'b0, 7'h40, 64'h0, 1'b0, 64'h66},                // R10
        '{2'd0, 2'd0, 2'd1, 1'b0, 7'h30, 64'h0, 1'b0, 64'h5A00},              // R9
        '{2'd2, 2'd0, 2'd3, 1'b0, 7'h20, 64'h0, 1'b0, 64'h0000CAFE00000000}   // R9
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic set_port(input int p, input logic [1:0] op, input logic [1:0] sz,
                            input logic sh, input logic [6:0] a, input logic [63:0] wd);
        req_op[p] = op; req_size[p] = sz; req_shared[p] = sh;
        req_addr[p] = a; req_wdata[p] = wd;
    endtask

    task automatic op1(input int p, input logic [1:0] op, input logic [1:0] sz,
                       input logic sh, input logic [6:0] a, input logic [63:0] wd,
                       input string req, output logic st, output logic [63:0] rd);
        @(negedge clk);
        set_port(p, op, sz, sh, a, wd);
        req_valid[p] = 1'b1;
        #1;
        for (int w = 0; w < 20 && !req_ready[p]; w++) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        chk(rsp_valid && rsp_port == PW'(p), {req, "/R3 rsp"}, {62'd0, rsp_port}, 64'(p));
        st = rsp_status;
        rd = rsp_rdata;
        req_valid[p] = 1'b0;
    endtask

    int gord [8];
    int ng;
    int rp [8];
    logic rs [8];
    int nr;

    task automatic issue_multi(input logic [NP-1:0] mask);
        logic [NP-1:0] prev;
        ng = 0; nr = 0;
        @(negedge clk);
        req_valid = mask;
        #1 prev = req_ready;
        for (int c = 0; c < NP + 3; c++) begin
            for (int b = 0; b < NP; b++) if (prev[b] && ng < 8) begin gord[ng] = b; ng++; end
            @(negedge clk);
            if (rsp_valid && nr < 8) begin rp[nr] = int'(rsp_port); rs[nr] = rsp_status; nr++; end
            req_valid = req_valid & ~prev;
            #1 prev = req_ready;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic st;
        logic [63:0] rd;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        @(negedge clk) rst_n = 1'b1;

        // R2 / R3: all four ports at once after reset
        for (int p = 0; p < NP; p++) set_port(p, 2'd0, 2'd2, 1'b0, 7'h08, 64'h0);
        issue_multi(4'b1111);
        chk(ng == 4, "R2 grant count", 64'(ng), 64'd4);
        for (int i = 0; i < 4; i++)
            chk(gord[i] == i, "R2 round robin order", 64'(gord[i]), 64'(i));
        chk(nr == 4, "R3 response count", 64'(nr), 64'd4);
        for (int i = 0; i < 4; i++)
            chk(rp[i] == i, "R3 rsp_port order", 64'(rp[i]), 64'(i));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R3 idle after burst", 64'(rsp_valid), 64'd0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            op1(int'(VT[v].port), VT[v].op, VT[v].size, VT[v].sh, VT[v].addr, VT[v].wdata,
                $sformatf("vec%0d", v), st, rd);
            chk(st == VT[v].est, $sformatf("vec%0d status (R4/R5/R7/R8/R10)", v), 64'(st), 64'(VT[v].est));
            chk(rd == VT[v].erd, $sformatf("vec%0d rdata (R4/R9/R11/R12)", v), rd, VT[v].erd);
        end

        // R10: race between two holders of the same granule
        op1(0, 2'd2, 2'd2, 1'b1, 7'h60, 64'h0, "R10 ldx p0", st, rd);
        op1(1, 2'd2, 2'd2, 1'b1, 7'h60, 64'h0, "R10 ldx p1", st, rd);
        set_port(0, 2'd3, 2'd2, 1'b1, 7'h60, 64'hA0);
        set_port(1, 2'd3, 2'd2, 1'b1, 7'h60, 64'hB1);
        issue_multi(4'b0011);
        chk(ng == 2 && gord[0] == 0, "R10 race winner first", 64'(gord[0]), 64'd0);
        chk(nr == 2 && rs[0] == 1'b0, "R10 race winner status", 64'(rs[0]), 64'd0);
        chk(nr == 2 && rs[1] == 1'b1, "R10 race loser status", 64'(rs[1]), 64'd1);
        op1(2, 2'd0, 2'd2, 1'b0, 7'h60, 64'h0, "R10 race data", st, rd);
        chk(rd == 64'hA0, "R10 race memory holds winner", rd, 64'hA0);

        // R1: reset drops reservations and clears memory
        op1(0, 2'd2, 2'd2, 1'b0, 7'h70, 64'h0, "R1 pre ldx p0", st, rd);
        op1(1, 2'd2, 2'd2, 1'b1, 7'h70, 64'h0, "R1 pre ldx p1", st, rd);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid low in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        op1(0, 2'd3, 2'd2, 1'b0, 7'h70, 64'h1, "R1 flag", st, rd);
        chk(st == 1'b1, "R1 non-shared flag cleared", 64'(st), 64'd1);
        op1(1, 2'd3, 2'd2, 1'b1, 7'h70, 64'h1, "R1 resv", st, rd);
        chk(st == 1'b1, "R1 shared reservation cleared", 64'(st), 64'd1);
        op1(0, 2'd0, 2'd2, 1'b0, 7'h08, 64'h0, "R1 mem", st, rd);
        chk(rd == 64'h0, "R1 memory cleared", rd, 64'h0);

        finish_up();
    end

endmodule